// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control around a successive-approximation converter. A programmable divider turns the CPU clock into an ADC clock. The block counts each conversion in ADC clock periods and issues a one-cycle sample strobe at the sample-and-hold point. At the end of each conversion it captures the converter's digital word, sets a completion flag and pulses a channel-update strobe. The first conversion after enable is longer, so that the analog front end can settle.

A conversion can be started in three ways. In single mode, software sets the start bit. In auto mode, a rising edge on an external trigger starts it; the trigger also realigns the divider, so the delay from trigger to sample is fixed. In free-running mode, each conversion starts the next one. The channel/reference selection is latched when a conversion starts and is shown on `chan_o`.

Top module: `adc_conv_seq`

## Requirements
- R1: The divider ratio is set by `presc_i`. Codes 0 to 7 give CPU-to-ADC ratios D of 2, 2, 4, 8, 16, 32, 64 and 128. While `en_i` is low the divider is held at zero. It starts counting in the cycle after `en_i` is first sampled high.
- R2: A start bit set in single mode starts a conversion on the next ADC clock rising edge, which is the last CPU cycle of a divider period.
- R3: The first conversion after enable lasts 25 ADC clock periods. Every later conversion lasts 13.
- R4: `sample_o` pulses for one CPU cycle. It comes 1.5 ADC periods after the start of a normal conversion and 14.5 ADC periods after the start of a first conversion.
- R5: At completion, `result_o` loads `adc_data_i`, `flag_o` goes high and `chan_upd_o` pulses. All three change on the same clock edge.
- R6: `mode_i` encodes 0 = single, 1 = free running, 2 = auto trigger, and 3 behaves as single. In single and auto modes, `start_o` clears at completion. In free mode it stays high, and the next conversion starts on the same edge.
- R7: In auto mode, a rising edge on `trig_i` passes through three synchronizer flops. It then sets the start bit and reloads the divider to D/2. `sample_o` therefore appears 3 + 2·D CPU cycles after the edge on which `trig_i` is first sampled high. Trigger edges are ignored while a conversion is running or pending.
- R8: A high `flag_clr_i` clears `flag_o`. If a clear and a completion fall on the same edge, the flag ends up set.
- R9: Dropping `en_i` aborts any conversion and leaves `result_o` and `flag_o` unchanged. The next conversion after re-enable is a 25-period first conversion.
- R10: `chan_o` loads `chan_i` when each conversion starts. Changes to `chan_i` during a conversion apply only to the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| start_i | input | 1 | Pulse that sets the start bit |
| mode_i | input | 2 | Start mode |
| presc_i | input | 3 | Divider select code |
| trig_i | input | 1 | External trigger level |
| flag_clr_i | input | 1 | Clears the completion flag |
| chan_i | input | 4 | Channel/reference selection |
| adc_data_i | input | 10 | Digital word from the converter |
| result_o | output | 10 | Result register |
| flag_o | output | 1 | Completion flag |
| start_o | output | 1 | Start bit state |
| busy_o | output | 1 | Conversion in progress |
| sample_o | output | 1 | Sample-and-hold strobe |
| chan_upd_o | output | 1 | Channel-update / end-of-conversion strobe |
| chan_o | output | 4 | Selection latched for the current conversion |

## Verification
Two functions can fall on the same clock edge: a completion that sets the flag and a software clear of that flag. The bench holds `flag_clr_i` high through an entire conversion, so the clear and the completion coincide. It then expects `flag_o` high in the cycle that `chan_upd_o` pulses and low one cycle later. A second coincidence occurs in free-running mode, where completion and the next start share an edge. The bench checks this by timing the second sample strobe and completion of each divider setting against 1.5·D and 13·D counted from the end of the first conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_RSVD   = 2'd3
  } conv_mode_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             load_half_i,
  output logic             tick_o,
  output logic             half_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, div_m1, half_m1;
  logic [SEL_W-1:0] shift;

  always_comb begin
    shift   = (sel_i == '0) ? SEL_W'(1) : sel_i;
    div_m1  = (CNT_W'(1) << shift) - CNT_W'(1);
    half_m1 = (CNT_W'(1) << (shift - SEL_W'(1))) - CNT_W'(1);
  end

  assign tick_o = en_i && (cnt_q == div_m1);
  assign half_o = en_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (load_half_i)       cnt_q <= half_m1 + CNT_W'(1);
    else if (cnt_q >= div_m1)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end

  p_held_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], trig_i};
  end

  assign edge_o = sync_q[STAGES-2] & ~sync_q[STAGES-1];

  p_edge_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int CH_W       = 4,
  parameter int NORM_CYC   = 13,
  parameter int FIRST_CYC  = 25,
  parameter int NORM_SAMP  = 2,
  parameter int FIRST_SAMP = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             flag_clr_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [RES_W-1:0] adc_data_i,
  input  logic             tick_i,
  input  logic             half_i,
  input  logic             trig_edge_i,
  output logic             load_half_o,
  output logic [RES_W-1:0] result_o,
  output logic             flag_o,
  output logic             start_o,
  output logic             busy_o,
  output logic             sample_o,
  output logic             chan_upd_o,
  output logic [CH_W-1:0]  chan_o
);
  localparam int CYC_W = $clog2(FIRST_CYC + 1);

  conv_mode_e       mode;
  logic             busy_q, start_q, first_pend_q, first_act_q;
  logic             sample_q, upd_q, flag_q;
  logic [CYC_W-1:0] cyc_q, last_cyc, samp_cyc;
  logic [RES_W-1:0] result_q;
  logic [CH_W-1:0]  chan_q;
  logic             done_now, begin_now, trig_take;

  assign mode     = conv_mode_e'(mode_i);
  assign last_cyc = first_act_q ? CYC_W'(FIRST_CYC)  : CYC_W'(NORM_CYC);
  assign samp_cyc = first_act_q ? CYC_W'(FIRST_SAMP) : CYC_W'(NORM_SAMP);

  assign done_now  = busy_q && tick_i && (cyc_q == last_cyc);
  // free mode chains the next conversion onto the completing edge
  assign begin_now = tick_i && start_q && (!busy_q || (done_now && mode == MODE_FREE));
  assign trig_take = en_i && trig_edge_i && (mode == MODE_AUTO) && !busy_q && !start_q;
  assign load_half_o = trig_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; start_q <= 1'b0; first_pend_q <= 1'b1; first_act_q <= 1'b0;
      cyc_q <= '0; sample_q <= 1'b0; upd_q <= 1'b0; chan_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0; start_q <= 1'b0; first_pend_q <= 1'b1;
      cyc_q <= '0; sample_q <= 1'b0; upd_q <= 1'b0;
    end else begin
      sample_q <= busy_q && half_i && (cyc_q == samp_cyc);
      upd_q    <= done_now;
      if (done_now && mode != MODE_FREE) start_q <= 1'b0;
      else if (start_i || trig_take)     start_q <= 1'b1;
      if (begin_now) begin
        busy_q       <= 1'b1;
        cyc_q        <= CYC_W'(1);
        first_act_q  <= first_pend_q;
        first_pend_q <= 1'b0;
        chan_q       <= chan_i;
      end else if (done_now) begin
        busy_q <= 1'b0;
      end else if (busy_q && tick_i) begin
        cyc_q <= cyc_q + CYC_W'(1);
      end
    end
  end

  // result and flag survive an abort
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0; flag_q <= 1'b0;
    end else if (done_now) begin
      result_q <= adc_data_i; flag_q <= 1'b1;
    end else if (flag_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign result_o   = result_q;
  assign flag_o     = flag_q;
  assign start_o    = start_q;
  assign busy_o     = busy_q;
  assign sample_o   = sample_q;
  assign chan_upd_o = upd_q;
  assign chan_o     = chan_q;

  p_samp_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_upd_o |-> flag_o);
  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_upd_o |-> $stable(result_o));
  p_single_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_upd_o && $past(mode_i != MODE_FREE)) |-> !start_o);
  p_free_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_upd_o && $past(mode_i == MODE_FREE)) |-> (start_o && busy_o));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int RES_W       = 10,
  parameter int CH_W        = 4,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 3,
  parameter int NORM_CYC    = 13,
  parameter int FIRST_CYC   = 25,
  parameter int NORM_SAMP   = 2,
  parameter int FIRST_SAMP  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] presc_i,
  input  logic             trig_i,
  input  logic             flag_clr_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [RES_W-1:0] adc_data_i,
  output logic [RES_W-1:0] result_o,
  output logic             flag_o,
  output logic             start_o,
  output logic             busy_o,
  output logic             sample_o,
  output logic             chan_upd_o,
  output logic [CH_W-1:0]  chan_o
);
  logic tick, half, trig_edge, load_half;

  adc_clk_div #(.SEL_W(SEL_W)) i_div (
    .clk_i, .rst_ni, .en_i, .sel_i(presc_i), .load_half_i(load_half),
    .tick_o(tick), .half_o(half)
  );

  adc_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .trig_i, .edge_o(trig_edge)
  );

  adc_conv_ctrl #(
    .RES_W(RES_W), .CH_W(CH_W), .NORM_CYC(NORM_CYC), .FIRST_CYC(FIRST_CYC),
    .NORM_SAMP(NORM_SAMP), .FIRST_SAMP(FIRST_SAMP)
  ) i_ctrl (
    .clk_i, .rst_ni, .en_i, .start_i, .mode_i, .flag_clr_i, .chan_i, .adc_data_i,
    .tick_i(tick), .half_i(half), .trig_edge_i(trig_edge), .load_half_o(load_half),
    .result_o, .flag_o, .start_o, .busy_o, .sample_o, .chan_upd_o, .chan_o
  );
endmodule

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, start_i = 1'b0, trig_i = 1'b0, flag_clr_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [2:0] presc_i = 3'd0;
  logic [3:0] chan_i = 4'd0;
  logic [9:0] adc_data_i = 10'd0;
  logic [9:0] result_o;
  logic       flag_o, start_o, busy_o, sample_o, chan_upd_o;
  logic [3:0] chan_o;

  int checks = 0, failures = 0;
  int s1, s2, d1, d2, ns;

  always #2.5 clk = ~clk;

  adc_conv_seq i_adc_conv_seq (
    .clk_i(clk), .rst_ni, .en_i, .start_i, .mode_i, .presc_i, .trig_i, .flag_clr_i,
    .chan_i, .adc_data_i, .result_o, .flag_o, .start_o, .busy_o, .sample_o,
    .chan_upd_o, .chan_o
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [9:0]  data;
    logic [15:0] s1, d1, s2, d2;
  } vec_t;

  // free-running runs from enable: s1=15.5D d1=26D s2=27.5D d2=39D
  localparam vec_t VECS [8] = '{
    '{3'd0, 10'h011, 16'd31,   16'd52,   16'd55,   16'd78},
    '{3'd1, 10'h022, 16'd31,   16'd52,   16'd55,   16'd78},
    '{3'd2, 10'h044, 16'd62,   16'd104,  16'd110,  16'd156},
    '{3'd3, 10'h088, 16'd124,  16'd208,  16'd220,  16'd312},
    '{3'd4, 10'h101, 16'd248,  16'd416,  16'd440,  16'd624},
    '{3'd5, 10'h202, 16'd496,  16'd832,  16'd880,  16'd1248},
    '{3'd6, 10'h3FF, 16'd992,  16'd1664, 16'd1760, 16'd2496},
    '{3'd7, 10'h155, 16'd1984, 16'd3328, 16'd3520, 16'd4992}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic rec(input int k);
    if (sample_o)   begin ns++; if (s1 < 0) s1 = k; else if (s2 < 0) s2 = k; end
    if (chan_upd_o) begin if (d1 < 0) d1 = k; else if (d2 < 0) d2 = k; end
  endtask

  task automatic clr_rec();
    s1 = -1; s2 = -1; d1 = -1; d2 = -1; ns = 0;
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(result_o == 10'd0, "R5", "reset result", result_o, 0);
    chk(flag_o == 1'b0, "R8", "reset flag", flag_o, 0);
    chk(start_o == 1'b0, "R6", "reset start", start_o, 0);
    chk(busy_o == 1'b0, "R3", "reset busy", busy_o, 0);
    chk(sample_o == 1'b0, "R4", "reset sample", sample_o, 0);
    chk(chan_upd_o == 1'b0, "R5", "reset chan_upd", chan_upd_o, 0);

    // table: free-running from enable, every divider code
    for (int v = 0; v < 8; v++) begin
      en_i = 1'b0;
      @(negedge clk);
      presc_i = VECS[v].sel; mode_i = 2'd1; adc_data_i = VECS[v].data;
      @(negedge clk);
      en_i = 1'b1; start_i = 1'b1;
      clr_rec();
      for (int k = 1; k <= int'(VECS[v].d2); k++) begin
        @(negedge clk);
        if (k == 1) start_i = 1'b0;
        rec(k);
      end
      chk(s1 == int'(VECS[v].s1), "R1 R4", "first sample cycle", s1, VECS[v].s1);
      chk(d1 == int'(VECS[v].d1), "R1 R3", "first completion cycle", d1, VECS[v].d1);
      chk(s2 == int'(VECS[v].s2), "R4", "normal sample cycle", s2, VECS[v].s2);
      chk(d2 == int'(VECS[v].d2), "R3 R6", "normal completion cycle", d2, VECS[v].d2);
      chk(start_o == 1'b1, "R6", "free start stays", start_o, 1);
      chk(busy_o == 1'b1, "R6", "free restart", busy_o, 1);
      chk(result_o == VECS[v].data, "R5", "free result", result_o, VECS[v].data);
    end

    // single mode, D=4: first conversion then a normal one
    @(negedge clk);
    en_i = 1'b0; flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0; presc_i = 3'd2; mode_i = 2'd0; chan_i = 4'd3; adc_data_i = 10'h2A5;
    @(negedge clk);
    en_i = 1'b1; start_i = 1'b1;
    clr_rec();
    for (int k = 1; k <= 104; k++) begin
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      if (k == 70) chan_i = 4'd6;
      rec(k);
    end
    chk(s1 == 62, "R4", "single first sample", s1, 62);
    chk(d1 == 104, "R3", "single first completion", d1, 104);
    chk(flag_o == 1'b1, "R5", "flag set", flag_o, 1);
    chk(start_o == 1'b0, "R6", "single start cleared", start_o, 0);
    chk(result_o == 10'h2A5, "R5", "single result", result_o, 10'h2A5);
    chk(chan_o == 4'd3, "R10", "channel held through conversion", chan_o, 3);

    start_i = 1'b1; flag_clr_i = 1'b1; adc_data_i = 10'h155;
    clr_rec();
    for (int j = 1; j <= 56; j++) begin
      @(negedge clk);
      if (j == 1) begin
        start_i = 1'b0; flag_clr_i = 1'b0;
        chk(flag_o == 1'b0, "R8", "flag cleared", flag_o, 0);
      end
      rec(j);
    end
    chk(s1 == 10, "R2 R4", "normal sample after start", s1, 10);
    chk(d1 == 56, "R2 R3", "normal completion after start", d1, 56);
    chk(result_o == 10'h155, "R5", "second result", result_o, 10'h155);
    chk(chan_o == 4'd6, "R10", "new channel applied", chan_o, 6);

    // clear held across completion
    start_i = 1'b1; flag_clr_i = 1'b1;
    for (int j = 1; j <= 57; j++) begin
      @(negedge clk);
      if (j == 1) start_i = 1'b0;
      if (j == 56) chk(flag_o == 1'b1 && chan_upd_o == 1'b1, "R8", "set wins over clear", flag_o, 1);
      if (j == 57) chk(flag_o == 1'b0, "R8", "clear after set", flag_o, 0);
    end
    flag_clr_i = 1'b0;

    // auto trigger, D=4, retrigger while busy
    @(negedge clk);
    mode_i = 2'd2; adc_data_i = 10'h0F0; trig_i = 1'b1;
    clr_rec();
    for (int j = 1; j <= 160; j++) begin
      @(negedge clk);
      if (j == 20) trig_i = 1'b0;
      if (j == 24) trig_i = 1'b1;
      rec(j);
    end
    trig_i = 1'b0;
    chk(s1 == 11, "R7", "trigger to sample", s1, 11);
    chk(d1 == 57, "R7", "trigger to completion", d1, 57);
    chk(ns == 1, "R7", "busy retrigger ignored", ns, 1);
    chk(start_o == 1'b0 && busy_o == 1'b0, "R6", "auto start cleared", start_o, 0);
    chk(result_o == 10'h0F0, "R5", "auto result", result_o, 10'h0F0);

    // abort mid conversion, then re-enable
    @(negedge clk);
    mode_i = 2'd0; en_i = 1'b0; flag_clr_i = 1'b1; adc_data_i = 10'h3C3;
    @(negedge clk);
    flag_clr_i = 1'b0; en_i = 1'b1; start_i = 1'b1;
    clr_rec();
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      rec(k);
    end
    en_i = 1'b0;
    repeat (2) begin @(negedge clk); rec(99); end
    chk(busy_o == 1'b0, "R9", "abort stops conversion", busy_o, 0);
    chk(d1 == -1, "R9", "no completion on abort", d1, -1);
    chk(flag_o == 1'b0, "R9", "flag untouched by abort", flag_o, 0);
    chk(result_o == 10'h0F0, "R9", "result untouched by abort", result_o, 10'h0F0);
    en_i = 1'b1; start_i = 1'b1;
    clr_rec();
    for (int k = 1; k <= 104; k++) begin
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      rec(k);
    end
    chk(s1 == 62, "R9", "first-length sample after re-enable", s1, 62);
    chk(d1 == 104, "R9", "first-length completion after re-enable", d1, 104);
    chk(result_o == 10'h3C3, "R5", "result after re-enable", result_o, 10'h3C3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule